// File: doc/BRIEF.md
# Region-Targeted Scan Stimulus Controller

This controller drives the scan-in pins and the test-enable line of a circuit whose scan chains were stitched by physical region. A region mask chooses which regions switch. Chains in the chosen regions receive pseudo-random bits. Every other chain is fed a constant zero, so switching stays local to the target area. This raises the share of any small parasitic logic in the total transient power when that power is measured.

Test-enable follows a programmable duty pattern. A number of shift cycles with test-enable high is followed by a number of capture cycles with it low, so logic that is active only in functional mode still gets exercised. A hold-high mode keeps the circuit in scan mode for the whole run. The run stops after a programmed number of vectors. An auto-step mode walks through every region subset up to a chosen size, one run per subset, in a fixed order.

The control path is a four-state machine:
- IDLE after reset.
- SHIFT, where test-enable is high and random data flows.
- CAPTURE, where test-enable is low and all scan inputs are zero.
- DONE, which holds until the next start.

The transitions between states are:
- IDLE→SHIFT and DONE→SHIFT on start.
- SHIFT→CAPTURE when the high count is used up.
- CAPTURE→SHIFT when the low count is used up.
- SHIFT→SHIFT at a mask change in auto-step.
- SHIFT→DONE after the last vector.

Top module: `localized_scan_ctrl`

## Requirements
- R1: After reset the block is idle. test_en, run_done, every scan_in bit and cur_mask are all 0.
- R2: Chain c belongs to region c mod NUM_REGIONS. In a shift cycle, chain c carries its generator bit when bit (c mod NUM_REGIONS) of cur_mask is 1, and carries 0 otherwise.
- R3: The generator is a 32-bit register s that advances once per shift cycle to {s[30:0], s[31]^s[21]^s[1]^s[0]} and holds in every other state. The bit for chain c is s[c mod 32] XOR s[(3c+5) mod 32].
- R4: On an accepted start, s is loaded from seed. A seed of zero loads 32'h9E3779B9 instead. The first shift cycle uses the loaded value.
- R5: Test-enable is high for shift_hi shift cycles, then low for capture_lo capture cycles, and this repeats. A count of zero behaves as 1. In a capture cycle every scan_in bit is 0.
- R6: With always_high set, no capture cycle occurs. Test-enable stays high from the first shift cycle to the last.
- R7: One vector is CHAIN_LEN shift cycles. After vec_count vectors (zero behaves as 1), the next cycle is DONE with no trailing capture. In DONE, test_en=0, scan_in=0 and run_done=1, and this holds until the next start.
- R8: Control inputs are sampled only when start is high in IDLE or DONE. A start during a run has no effect.
- R9: In auto-step, the first mask is 1. Each following run uses the next mask in order of increasing popcount, then increasing value, limited to popcount ≤ max_fanin (0 acts as 1, values above NUM_REGIONS act as NUM_REGIONS). DONE follows the last such mask.
- R10: cur_mask shows the mask of the current run. Between auto-step masks the block goes from the last shift cycle straight into the next run's first shift cycle. In that step run_done stays low, the generator is not reloaded, and the duty count starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted in IDLE or DONE) |
| region_mask | input | NUM_REGIONS | Target regions when auto-step is off |
| shift_hi | input | HI_W | Shift cycles per high phase |
| capture_lo | input | LO_W | Capture cycles per low phase |
| always_high | input | 1 | Keep test-enable high all run |
| vec_count | input | VEC_W | Vectors per run |
| max_fanin | input | IM_W | Largest subset size in auto-step |
| auto_step | input | 1 | Walk all subsets up to max_fanin |
| seed | input | 32 | Generator seed |
| scan_in | output | NUM_CHAINS | Scan-in data per chain |
| test_en | output | 1 | Shift (1) / capture (0) |
| run_done | output | 1 | Run or subset walk finished |
| cur_mask | output | NUM_REGIONS | Mask in force |

## Verification
The hardest case to reach is the subset walk. It crosses a popcount boundary (from 4'b1100 to 4'b0111 and beyond) and ends on the clamp set by max_fanin, and it must do so without ever raising run_done between masks. The bench reaches it by starting one-vector runs in auto-step with max_fanin of 0, 2 and a value above the region count, and comparing every cycle against a behavioural model. That model finds the next subset by brute-force search rather than bit arithmetic. Other runs put starts in the middle of a shift phase, use zero counts, and end a vector on the same cycle as a high-phase boundary.

// File: rtl/localscan_pkg.sv
package localscan_pkg;
    localparam int GEN_W = 32;
    localparam logic [GEN_W-1:0] FALLBACK_SEED = 32'h9E37_79B9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/ls_prbs_gen.sv
module ls_prbs_gen
    import localscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GEN_W-1:0] seed_in,
    input  logic             step,
    output logic [GEN_W-1:0] gen_state
);
    logic [GEN_W-1:0] gen_q;
    logic             fb;

    assign fb = gen_q[31] ^ gen_q[21] ^ gen_q[1] ^ gen_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= FALLBACK_SEED;
        end else if (load) begin
            gen_q <= (seed_in == '0) ? FALLBACK_SEED : seed_in;
        end else if (step) begin
            gen_q <= {gen_q[GEN_W-2:0], fb};
        end
    end

    assign gen_state = gen_q;
endmodule

// File: rtl/ls_region_mix.sv
module ls_region_mix
    import localscan_pkg::*;
#(
    parameter int NUM_CHAINS  = 48,
    parameter int NUM_REGIONS = 4
) (
    input  logic [GEN_W-1:0]       gen_state,
    input  logic [NUM_REGIONS-1:0] region_sel,
    input  logic                   enable,
    output logic [NUM_CHAINS-1:0]  chain_bits
);
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        localparam int TAP_A = c % GEN_W;
        localparam int TAP_B = (3 * c + 5) % GEN_W;
        localparam int REGION = c % NUM_REGIONS;
        assign chain_bits[c] = enable & region_sel[REGION]
                             & (gen_state[TAP_A] ^ gen_state[TAP_B]);
    end
endmodule

// File: rtl/ls_subset_step.sv
module ls_subset_step #(
    parameter int NUM_REGIONS = 4,
    parameter int IM_W        = 3
) (
    input  logic [NUM_REGIONS-1:0] cur_mask,
    input  logic [IM_W-1:0]        fanin_lim,
    output logic [NUM_REGIONS-1:0] nxt_mask,
    output logic                   nxt_ok
);
    logic [NUM_REGIONS:0]   xv;
    logic [NUM_REGIONS:0]   lowb;
    logic [NUM_REGIONS:0]   sumv;
    logic [NUM_REGIONS-1:0] ripv;
    int                     tz;
    int                     pop;
    int                     lim;

    always_comb begin
        xv   = {1'b0, cur_mask};
        lowb = xv & (~xv + 1'b1);
        sumv = xv + lowb;
        tz   = 0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (cur_mask[i]) tz = i;
        end
        pop = 0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (cur_mask[i]) pop++;
        end
        lim = (fanin_lim == '0) ? 1 : int'(fanin_lim);
        if (lim > NUM_REGIONS) lim = NUM_REGIONS;
        ripv = NUM_REGIONS'(((sumv ^ xv) >> 2) >> tz);
        nxt_mask = '0;
        nxt_ok   = 1'b0;
        if (cur_mask != '0) begin
            if (!sumv[NUM_REGIONS]) begin
                nxt_mask = sumv[NUM_REGIONS-1:0] | ripv;
                nxt_ok   = 1'b1;
            end else if (pop < lim) begin
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    nxt_mask[i] = (i <= pop);
                end
                nxt_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/localized_scan_ctrl.sv
module localized_scan_ctrl
    import localscan_pkg::*;
#(
    parameter int NUM_CHAINS  = 48,
    parameter int NUM_REGIONS = 4,
    parameter int CHAIN_LEN   = 8,
    parameter int HI_W        = 8,
    parameter int LO_W        = 8,
    parameter int VEC_W       = 16,
    localparam int IM_W       = $clog2(NUM_REGIONS + 1),
    localparam int SH_W       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_REGIONS-1:0] region_mask,
    input  logic [HI_W-1:0]        shift_hi,
    input  logic [LO_W-1:0]        capture_lo,
    input  logic                   always_high,
    input  logic [VEC_W-1:0]       vec_count,
    input  logic [IM_W-1:0]        max_fanin,
    input  logic                   auto_step,
    input  logic [GEN_W-1:0]       seed,
    output logic [NUM_CHAINS-1:0]  scan_in,
    output logic                   test_en,
    output logic                   run_done,
    output logic [NUM_REGIONS-1:0] cur_mask
);
    scan_state_e state_q, state_d;

    logic [HI_W-1:0]        hi_len_q, hi_q;
    logic [LO_W-1:0]        lo_len_q, lo_q;
    logic [VEC_W-1:0]       vec_lim_q, vec_q;
    logic [SH_W-1:0]        sh_q;
    logic                   hold_high_q, auto_q;
    logic [IM_W-1:0]        fanin_q;
    logic [NUM_REGIONS-1:0] mask_q;

    logic                   accept, vec_end, run_end, chain_next, hi_end, lo_end;
    logic [NUM_REGIONS-1:0] step_mask;
    logic                   step_ok;
    logic [GEN_W-1:0]       gen_state;
    logic [NUM_CHAINS-1:0]  mixed;
    logic                   shifting;

    assign accept     = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign shifting   = (state_q == ST_SHIFT);
    assign vec_end    = shifting && (sh_q == SH_W'(CHAIN_LEN - 1));
    assign run_end    = vec_end && (vec_q == vec_lim_q - VEC_W'(1));
    assign chain_next = run_end && auto_q && step_ok;
    assign hi_end     = (hi_q == hi_len_q - HI_W'(1));
    assign lo_end     = (lo_q == lo_len_q - LO_W'(1));

    ls_prbs_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .seed_in   (seed),
        .step      (shifting),
        .gen_state (gen_state)
    );

    ls_region_mix #(
        .NUM_CHAINS  (NUM_CHAINS),
        .NUM_REGIONS (NUM_REGIONS)
    ) u_mix (
        .gen_state  (gen_state),
        .region_sel (mask_q),
        .enable     (shifting),
        .chain_bits (mixed)
    );

    ls_subset_step #(
        .NUM_REGIONS (NUM_REGIONS),
        .IM_W        (IM_W)
    ) u_step (
        .cur_mask  (mask_q),
        .fanin_lim (fanin_q),
        .nxt_mask  (step_mask),
        .nxt_ok    (step_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (run_end)                        state_d = chain_next ? ST_SHIFT : ST_DONE;
                else if (!hold_high_q && hi_end)    state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (lo_end) state_d = ST_SHIFT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // configuration and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q    <= HI_W'(1);
            lo_len_q    <= LO_W'(1);
            vec_lim_q   <= VEC_W'(1);
            hold_high_q <= 1'b0;
            auto_q      <= 1'b0;
            fanin_q     <= '0;
            mask_q      <= '0;
            sh_q        <= '0;
            vec_q       <= '0;
            hi_q        <= '0;
            lo_q        <= '0;
        end else if (accept) begin
            hi_len_q    <= (shift_hi == '0) ? HI_W'(1) : shift_hi;
            lo_len_q    <= (capture_lo == '0) ? LO_W'(1) : capture_lo;
            vec_lim_q   <= (vec_count == '0) ? VEC_W'(1) : vec_count;
            hold_high_q <= always_high;
            auto_q      <= auto_step;
            fanin_q     <= max_fanin;
            mask_q      <= auto_step ? NUM_REGIONS'(1) : region_mask;
            sh_q        <= '0;
            vec_q       <= '0;
            hi_q        <= '0;
            lo_q        <= '0;
        end else if (state_q == ST_SHIFT) begin
            sh_q <= vec_end ? '0 : sh_q + SH_W'(1);
            hi_q <= hi_q + HI_W'(1);
            if (vec_end) vec_q <= vec_q + VEC_W'(1);
            if (chain_next) begin
                mask_q <= step_mask;
                vec_q  <= '0;
                hi_q   <= '0;
            end
            if (!run_end && !hold_high_q && hi_end) lo_q <= '0;
        end else if (state_q == ST_CAPTURE) begin
            lo_q <= lo_q + LO_W'(1);
            if (lo_end) hi_q <= '0;
        end
    end

    // outputs
    always_comb begin
        test_en  = shifting;
        run_done = (state_q == ST_DONE);
        scan_in  = mixed;
        cur_mask = mask_q;
    end
endmodule

// File: rtl/ls_ctrl_checker.sv
module ls_ctrl_checker #(
    parameter int NUM_CHAINS  = 48,
    parameter int NUM_REGIONS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [NUM_CHAINS-1:0]  scan_in,
    input logic                   test_en,
    input logic                   run_done,
    input logic [NUM_REGIONS-1:0] cur_mask
);
    logic [NUM_CHAINS-1:0] region_bits;

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_rb
        assign region_bits[c] = cur_mask[c % NUM_REGIONS];
    end

    assert_quiet_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (scan_in == '0));

    assert_unselected_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_in & ~region_bits) == '0);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> !test_en);

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !start) |=> run_done);

    assert_done_mask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !start) |=> $stable(cur_mask));

    assert_walk_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && $past(test_en) && cur_mask != $past(cur_mask))
        |-> ($countones(cur_mask) >= $countones($past(cur_mask))));
endmodule

bind localized_scan_ctrl ls_ctrl_checker #(
    .NUM_CHAINS  (NUM_CHAINS),
    .NUM_REGIONS (NUM_REGIONS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scan_in  (scan_in),
    .test_en  (test_en),
    .run_done (run_done),
    .cur_mask (cur_mask)
);

// File: tb/localized_scan_ctrl_tb.sv
module localized_scan_ctrl_tb;
    localparam int NC = 48;
    localparam int NR = 4;
    localparam int CL = 8;
    localparam int IMW = $clog2(NR + 1);
    localparam logic [31:0] DEF_SEED = 32'h9E37_79B9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NR-1:0] region_mask = '0;
    logic [7:0]    shift_hi = '0;
    logic [7:0]    capture_lo = '0;
    logic          always_high = 1'b0;
    logic [15:0]   vec_count = '0;
    logic [IMW-1:0] max_fanin = '0;
    logic          auto_step = 1'b0;
    logic [31:0]   seed = '0;
    logic [NC-1:0] scan_in;
    logic          test_en;
    logic          run_done;
    logic [NR-1:0] cur_mask;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    localized_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .region_mask(region_mask),
        .shift_hi(shift_hi), .capture_lo(capture_lo), .always_high(always_high),
        .vec_count(vec_count), .max_fanin(max_fanin), .auto_step(auto_step),
        .seed(seed), .scan_in(scan_in), .test_en(test_en), .run_done(run_done),
        .cur_mask(cur_mask)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic logic [31:0] adv(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [NC-1:0] expect_bits(input logic [31:0] s, input int msk);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++)
            r[c] = msk[c % NR] & (s[c % 32] ^ s[(3 * c + 5) % 32]);
        return r;
    endfunction

    function automatic int pc(input int v);
        int n = 0;
        for (int i = 0; i < NR; i++) if (v[i]) n++;
        return n;
    endfunction

    function automatic bit next_subset(input int cur, input int im, output int nv);
        int lim = (im == 0) ? 1 : im;
        if (lim > NR) lim = NR;
        nv = 0;
        for (int v = cur + 1; v < (1 << NR); v++)
            if (pc(v) == pc(cur)) begin nv = v; return 1; end
        if (pc(cur) + 1 <= lim) begin nv = (1 << (pc(cur) + 1)) - 1; return 1; end
        return 0;
    endfunction

    int ms = 0;           // 0 idle, 1 shift, 2 capture, 3 done
    logic [31:0] ml = DEF_SEED;
    int mm = 0, m_sh = 0, m_vec = 0, m_hi = 0, m_lo = 0;
    int cH = 1, cL = 1, cK = 1, cIm = 0;
    bit cAH = 0, cAuto = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0; ml = DEF_SEED; mm = 0;
        end else begin
            case (ms)
                0, 3: if (start) begin
                    cH = (shift_hi == 0) ? 1 : int'(shift_hi);
                    cL = (capture_lo == 0) ? 1 : int'(capture_lo);
                    cK = (vec_count == 0) ? 1 : int'(vec_count);
                    cAH = always_high; cAuto = auto_step; cIm = int'(max_fanin);
                    ml = (seed == 0) ? DEF_SEED : seed;
                    mm = auto_step ? 1 : int'(region_mask);
                    m_sh = 0; m_vec = 0; m_hi = 0; m_lo = 0; ms = 1;
                end
                1: begin
                    bit endv;
                    int nv;
                    endv = (m_sh == CL - 1);
                    ml = adv(ml);
                    m_hi++;
                    if (endv) begin m_sh = 0; m_vec++; end else m_sh++;
                    if (endv && m_vec == cK) begin
                        if (cAuto && next_subset(mm, cIm, nv)) begin
                            mm = nv; m_vec = 0; m_hi = 0;
                        end else ms = 3;
                    end else if (!cAH && m_hi == cH) begin
                        ms = 2; m_lo = 0;
                    end
                end
                2: begin
                    m_lo++;
                    if (m_lo == cL) begin ms = 1; m_hi = 0; end
                end
                default: ms = 0;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [NC-1:0] es;
            es = (ms == 1) ? expect_bits(ml, mm) : '0;
            chk(scan_in === es, "R2/R3", "scan_in", 64'(scan_in), 64'(es));
            chk(test_en === (ms == 1), "R5/R6", "test_en", 64'(test_en), 64'(ms == 1));
            chk(run_done === (ms == 3), "R7", "run_done", 64'(run_done), 64'(ms == 3));
            chk(cur_mask === mm[NR-1:0], "R9/R10", "cur_mask", 64'(cur_mask), 64'(mm));
        end
    end

    // ---------------- stimulus ----------------
    task automatic go(input int msk, input int h, input int l, input bit ah,
                      input int k, input int im, input bit au, input logic [31:0] sd);
        @(negedge clk);
        region_mask = msk[NR-1:0]; shift_hi = h[7:0]; capture_lo = l[7:0];
        always_high = ah; vec_count = k[15:0]; max_fanin = im[IMW-1:0];
        auto_step = au; seed = sd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    int te_n, lo_n, masks_n, last_mask;
    logic [NC-1:0] seen_or;

    task automatic wait_done();
        int guard = 0;
        int prev = -1;
        te_n = 0; lo_n = 0; masks_n = 0; seen_or = '0;
        while (!run_done && guard < 20000) begin
            if (test_en) te_n++; else lo_n++;
            if (int'(cur_mask) != prev) begin masks_n++; prev = int'(cur_mask); end
            seen_or |= scan_in;
            last_mask = int'(cur_mask);
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [NC-1:0] sel_mask;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(test_en === 1'b0, "R1", "test_en", 64'(test_en), 0);
        chk(run_done === 1'b0, "R1", "run_done", 64'(run_done), 0);
        chk(scan_in === '0, "R1", "scan_in", 64'(scan_in), 0);
        chk(cur_mask === '0, "R1", "cur_mask", 64'(cur_mask), 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // Run A: regions 0 and 2, 3 high / 1 low, 4 vectors
        go(4'b0101, 3, 1, 0, 4, 0, 0, 32'h1234_5678);
        wait_done();
        chk(te_n == 4 * CL, "R7", "shift cycles", 64'(te_n), 32);
        chk(lo_n == 10, "R5", "capture cycles", 64'(lo_n), 10);
        sel_mask = '0;
        for (int c = 0; c < NC; c++) sel_mask[c] = ((c % NR) == 0) || ((c % NR) == 2);
        chk((seen_or & ~sel_mask) == '0, "R2", "unselected activity", 64'(seen_or & ~sel_mask), 0);
        chk((seen_or & sel_mask) != '0, "R2", "selected activity", 64'(seen_or & sel_mask), 1);
        repeat (3) @(negedge clk);
        chk(run_done === 1'b1, "R7", "done held", 64'(run_done), 1);

        // 1/1 duty on region 3
        go(4'b1000, 1, 1, 0, 2, 0, 0, 32'hCAFE_0001);
        wait_done();
        chk(lo_n == 2 * CL - 1, "R5", "1/1 capture cycles", 64'(lo_n), 2 * CL - 1);

        // 10/1 duty, start pulsed mid-run is ignored
        go(4'b1111, 10, 1, 0, 3, 0, 0, 32'h0BAD_F00D);
        repeat (4) @(negedge clk);
        region_mask = 4'b0001; vec_count = 16'd50; auto_step = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cur_mask === 4'b1111, "R8", "mask after busy start", 64'(cur_mask), 15);
        wait_done();
        chk(te_n == 3 * CL - 5, "R8", "remaining shift cycles", 64'(te_n), 3 * CL - 5);

        // hold-high mode
        go(4'b0011, 2, 5, 1, 5, 0, 0, 32'h5555_AAAA);
        wait_done();
        chk(lo_n == 0, "R6", "low cycles in hold-high", 64'(lo_n), 0);
        chk(te_n == 5 * CL, "R6", "hold-high shift cycles", 64'(te_n), 5 * CL);

        // zero seed uses the fallback
        go(4'b1111, 30, 1, 0, 1, 0, 0, 32'h0);
        chk(scan_in === expect_bits(DEF_SEED, 15), "R4", "first bits from fallback",
            64'(scan_in), 64'(expect_bits(DEF_SEED, 15)));
        wait_done();

        // zero counts behave as 1
        go(4'b0110, 0, 0, 0, 0, 0, 0, 32'h0000_0077);
        wait_done();
        chk(te_n == CL, "R7", "zero vec_count", 64'(te_n), CL);
        chk(lo_n == CL - 1, "R5", "zero H/L", 64'(lo_n), CL - 1);

        // auto-step walks, fan-in 2
        go(4'b0000, 30, 1, 0, 1, 2, 1, 32'h1357_9BDF);
        wait_done();
        chk(masks_n == 10, "R9", "subsets fan-in 2", 64'(masks_n), 10);
        chk(last_mask == 12, "R9", "last subset fan-in 2", 64'(last_mask), 12);
        chk(lo_n == 0, "R10", "no gap between masks", 64'(lo_n), 0);

        // fan-in 0 acts as 1
        go(4'b0000, 3, 2, 0, 1, 0, 1, 32'h2468_ACE0);
        wait_done();
        chk(masks_n == 4, "R9", "subsets fan-in 0", 64'(masks_n), 4);
        chk(last_mask == 8, "R9", "last subset fan-in 0", 64'(last_mask), 8);

        // fan-in above region count clamps
        go(4'b0000, 0, 0, 1, 1, 7, 1, 32'hFFFF_0000);
        wait_done();
        chk(masks_n == 15, "R9", "subsets clamped", 64'(masks_n), 15);
        chk(te_n == 15 * CL, "R10", "continuous walk", 64'(te_n), 15 * CL);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule